// File: doc/BRIEF.md
# Buffered 16-bit reloadable timer

The block is an up-counter that sits on an 8-bit register bus and counts clock-enable ticks. It can run as an 8-bit or a 16-bit counter. It can take its ticks from an internal tick or an external tick. The ticks can go through a power-of-two prescaler or skip it. A sticky overflow flag records each rollover until software clears it.

Software never touches the counter's upper byte directly. Writes to the upper-byte address only fill a buffer register. A write to the lower byte then loads both bytes of the counter in one cycle. Going the other way, a read of the lower byte copies the live upper byte into the same buffer. A later read of the upper-byte address returns that copy. Both 16-bit reads and 16-bit writes are therefore coherent, even while the counter runs.

Top module: `tmr_shadow16`

## Requirements
- R1: After reset the timer is stopped, the control register reads 0x00, the count is 0x0000, the buffer is 0x00 and the flag is clear. The register addresses are: 0 control, 1 count low byte, 2 buffered high byte, 3 status with the flag in bit 0.
- R2: The count changes only while control bit 7 (run) is 1. With run at 0, ticks leave the count unchanged.
- R3: Control bit 6 at 0 selects 8-bit mode. In this mode only the low byte counts, a wrap of the low byte from 0xFF to 0x00 sets the flag, and the high byte holds. With bit 6 at 1 the full 16-bit value counts.
- R4: Control bit 5 selects the tick source: 0 takes int_tick and 1 takes ext_tick. The tick that is not selected has no effect.
- R5: With control bit 3 at 1 the counter steps on every selected tick. With bit 3 at 0 it steps once per 2^(N+1) ticks, where N is control bits 2:0.
- R6: A write to address 2 loads only the buffer. A write to address 1 loads the low byte and copies the buffer into the high byte in the same cycle. If the buffer was not rewritten in between, its old contents are committed again.
- R7: A read of address 1 returns the low byte and captures the live high byte into the buffer. A read of address 2 returns the buffer, not the live high byte. Read data appears on the cycle after the read strobe.
- R8: The flag sets when the count wraps to zero and stays set until a write to address 3 with bit 0 at 1. After a preload of 0xFC02 in 16-bit mode with no prescaling, the flag rises on exactly the 1022nd tick.
- R9: Any write to address 1 or address 2 clears the prescaler's partial count.
- R10: When a write to address 1 and a counting tick fall in the same cycle, the written value is loaded and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| int_tick | input | 1 | Internal count enable |
| ext_tick | input | 1 | External count enable |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the buffer's ordering rules. Reading the upper address after a lower-byte read must return the snapshot. An upper-byte write followed by a readback must return the buffered value. A lower-byte write with no fresh upper-byte write must commit the old buffer again. A design that routed the upper address straight to the counter, or that failed to snapshot, returns the wrong byte in these steps.

The 0xFC02 preload must raise the flag on exactly the 1022nd tick, so an off-by-one in the overflow point shows up directly. The 8-bit test rolls the low byte past 0xFF: a design that let the high byte count, or missed the narrow wrap, fails there. Two further tests target the corner cases of R9 and R10. A tick that arrives together with a lower-byte write must not increment the loaded value. A prescaler left half-full across a write would step early after that write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PS_W = 3;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOW  = 2'd1,
    REG_HIGH = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_t;

  typedef struct packed {
    logic            run;
    logic            wide;
    logic            src_ext;
    logic            rsvd;
    logic            pre_off;
    logic [PS_W-1:0] ratio;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            tick,
  input  logic            bypass,
  input  logic [PS_W-1:0] ratio,
  output logic            step
);
  localparam int CW = 1 << PS_W;

  logic [CW-1:0] acc;
  logic [CW-1:0] mask;

  // terminal value: ratio+1 low bits set
  generate
    for (genvar i = 0; i < CW; i++) begin : g_mask
      assign mask[i] = (PS_W'(i) <= ratio);
    end
  endgenerate

  assign step = tick && (bypass || (acc == mask));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (tick && !bypass) begin
      acc <= (acc == mask) ? '0 : acc + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2*BW-1:0] load_val,
  input  logic          step,
  input  logic          wide,
  output logic [2*BW-1:0] cnt,
  output logic          ovf
);
  assign ovf = step && !load && (wide ? (&cnt) : (&cnt[BW-1:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step) begin
      if (wide) cnt <= cnt + 1'b1;
      else      cnt[BW-1:0] <= cnt[BW-1:0] + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_shadow16.sv
module tmr_shadow16 #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [BW-1:0] bus_rdata,
  input  logic          int_tick,
  input  logic          ext_tick,
  output logic          ovf_flag
);
  import tmr_pkg::*;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
  localparam int CNT_W  = 2 * BW;

  tmr_ctrl_t        ctrl_q;
  logic [BW-1:0]    shadow_q;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             step;
  logic             wr_lo, wr_hi, wr_ct, wr_st, rd_lo;
  logic             run_tick;

  assign wr_lo = bus_wr && (bus_addr == REG_LOW);
  assign wr_hi = bus_wr && (bus_addr == REG_HIGH);
  assign wr_ct = bus_wr && (bus_addr == REG_CTRL);
  assign wr_st = bus_wr && (bus_addr == REG_STAT);
  assign rd_lo = bus_rd && (bus_addr == REG_LOW);

  assign run_tick = ctrl_q.run && (ctrl_q.src_ext ? ext_tick : int_tick);

  tmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .clr(wr_lo || wr_hi), .tick(run_tick),
    .bypass(ctrl_q.pre_off), .ratio(ctrl_q.ratio), .step(step)
  );

  tmr_count #(.BW(BW)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_lo), .load_val({shadow_q, bus_wdata}),
    .step(step), .wide(ctrl_q.wide), .cnt(cnt), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ct) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)        shadow_q <= '0;
    else if (wr_hi) shadow_q <= bus_wdata;
    else if (rd_lo) shadow_q <= cnt[CNT_W-1:BW];
  end

  always_ff @(posedge clk) begin
    if (rst)                      ovf_flag <= 1'b0;
    else if (ovf)                 ovf_flag <= 1'b1;
    else if (wr_st && bus_wdata[0]) ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        REG_CTRL: bus_rdata <= BW'(ctrl_q);
        REG_LOW:  bus_rdata <= cnt[BW-1:0];
        REG_HIGH: bus_rdata <= shadow_q;
        default:  bus_rdata <= BW'(ovf_flag);
      endcase
    end
  end
endmodule

// File: rtl/tmr_shadow16_chk.sv
module tmr_shadow16_chk #(
  parameter int BW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic [BW-1:0]     bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input tmr_pkg::tmr_ctrl_t ctrl_q,
  input logic [BW-1:0]     shadow_q,
  input logic [2*BW-1:0]   cnt,
  input logic              ovf_flag
);
  logic w_lo, w_hi, w_st, r_lo;
  assign w_lo = bus_wr && (bus_addr == 2'd1);
  assign w_hi = bus_wr && (bus_addr == 2'd2);
  assign w_st = bus_wr && (bus_addr == 2'd3);
  assign r_lo = bus_rd && (bus_addr == 2'd1);

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !w_lo) |=> (cnt == $past(cnt))); // R2
  AST_NARROW_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.wide && !w_lo) |=> (cnt[2*BW-1:BW] == $past(cnt[2*BW-1:BW]))); // R3
  AST_HIGH_WRITE_BUFFER: assert property (@(posedge clk) disable iff (rst)
    w_hi |=> (shadow_q == $past(bus_wdata))); // R6
  AST_LOW_WRITE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    w_lo |=> (cnt == {$past(shadow_q), $past(bus_wdata)})); // R10
  AST_LOW_READ_SNAP: assert property (@(posedge clk) disable iff (rst)
    (r_lo && !w_hi) |=> (shadow_q == $past(cnt[2*BW-1:BW]))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(w_st && bus_wdata[0])) |=> ovf_flag); // R8
endmodule

bind tmr_shadow16 tmr_shadow16_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .ctrl_q(ctrl_q), .shadow_q(shadow_q),
  .cnt(cnt), .ovf_flag(ovf_flag)
);

// File: tb/sim_tmr_shadow16.sv
module sim_tmr_shadow16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       int_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       ovf_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_shadow16 #(.BW(8)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .int_tick(int_tick), .ext_tick(ext_tick), .ovf_flag(ovf_flag)
  );

  // {op(2): 0 write / 1 read, addr(2), data(8), expected read(8)}
  localparam int NV = 16;
  localparam logic [19:0] VEC [0:NV-1] = '{
    {2'd0, 2'd2, 8'h12, 8'h00},
    {2'd0, 2'd1, 8'h34, 8'h00},
    {2'd1, 2'd1, 8'h00, 8'h34},
    {2'd1, 2'd2, 8'h00, 8'h12},
    {2'd0, 2'd2, 8'h56, 8'h00},
    {2'd1, 2'd2, 8'h00, 8'h56},
    {2'd1, 2'd1, 8'h00, 8'h34},
    {2'd1, 2'd2, 8'h00, 8'h12},
    {2'd0, 2'd1, 8'h9A, 8'h00},
    {2'd1, 2'd1, 8'h00, 8'h9A},
    {2'd1, 2'd2, 8'h00, 8'h12},
    {2'd0, 2'd2, 8'hAB, 8'h00},
    {2'd0, 2'd1, 8'hCD, 8'h00},
    {2'd1, 2'd2, 8'h00, 8'hAB},
    {2'd1, 2'd1, 8'h00, 8'hCD},
    {2'd1, 2'd2, 8'h00, 8'hAB}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n, input logic ext);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ext) ext_tick = 1'b1; else int_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0; int_tick = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 flag", 16'(ovf_flag), 16'h0);
    rd(2'd0, r); check("R1 ctrl", 16'(r), 16'h00);
    rd(2'd1, r); check("R1 low", 16'(r), 16'h00);
    rd(2'd2, r); check("R1 high", 16'(r), 16'h00);
    rd(2'd3, r); check("R1 status", 16'(r), 16'h00);

    // R6/R7 buffer ordering table, timer stopped
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][19:18] == 2'd0) wr(VEC[k][17:16], VEC[k][15:8]);
      else begin
        rd(VEC[k][17:16], r);
        check("R6/R7 table", 16'(r), 16'(VEC[k][7:0]));
      end
    end

    // R3 8-bit mode wrap, high byte held
    wr(2'd2, 8'h12); wr(2'd1, 8'hFD);
    wr(2'd0, 8'h88);
    ticks(2, 1'b0);
    check("R3 no flag before wrap", 16'(ovf_flag), 16'h0);
    ticks(1, 1'b0);
    check("R3 flag on low wrap", 16'(ovf_flag), 16'h1);
    ticks(1, 1'b0);
    wr(2'd0, 8'h08);
    rd(2'd1, r); check("R3 low", 16'(r), 16'h01);
    rd(2'd2, r); check("R3 high held", 16'(r), 16'h12);

    // R8 sticky flag, write-one-to-clear
    check("R8 still set", 16'(ovf_flag), 16'h1);
    wr(2'd3, 8'h00);
    check("R8 zero write keeps", 16'(ovf_flag), 16'h1);
    wr(2'd3, 8'h01);
    check("R8 cleared", 16'(ovf_flag), 16'h0);

    // R2 stopped timer ignores ticks
    ticks(5, 1'b0);
    rd(2'd1, r); check("R2 stopped", 16'(r), 16'h01);

    // R4 source select
    wr(2'd0, 8'hA8);
    ticks(4, 1'b0);
    rd(2'd1, r); check("R4 int ignored", 16'(r), 16'h01);
    ticks(3, 1'b1);
    rd(2'd1, r); check("R4 ext counts", 16'(r), 16'h04);

    // R5 prescaler divide by 4
    wr(2'd0, 8'h41); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    wr(2'd0, 8'hC1);
    ticks(8, 1'b0);
    rd(2'd1, r); check("R5 div4", 16'(r), 16'h02);

    // R9 counter write clears the prescaler
    ticks(3, 1'b0);
    wr(2'd1, 8'h10);
    ticks(1, 1'b0);
    rd(2'd1, r); check("R9 no early step", 16'(r), 16'h10);
    ticks(3, 1'b0);
    rd(2'd1, r); check("R9 fresh period", 16'(r), 16'h11);

    // R10 write wins over a same-cycle tick
    wr(2'd0, 8'hC8); wr(2'd2, 8'h00);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h40; bus_wr = 1'b1; int_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; int_tick = 1'b0;
    wr(2'd0, 8'h48);
    rd(2'd1, r); check("R10 tick dropped", 16'(r), 16'h40);

    // R8 timing: 0xFC02 preload overflows on the 1022nd tick
    wr(2'd3, 8'h01);
    wr(2'd2, 8'hFC); wr(2'd1, 8'h02);
    wr(2'd0, 8'hC8);
    n = 0;
    while (!ovf_flag && n < 2000) begin
      ticks(1, 1'b0);
      n++;
    end
    check("R8 1022 ticks", 16'(n), 16'd1022);
    wr(2'd0, 8'h48);
    rd(2'd1, r); check("R8 low wrapped", 16'(r), 16'h00);
    rd(2'd2, r); check("R8 high wrapped", 16'(r), 16'h00);

    finish_run();
  end
endmodule